// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block performs the hardware side of taking an interrupt on a small 8-bit processor. It watches a set of interrupt sources. Each source has a flag and a local enable. The block also watches the global mask bit in the condition byte and a strobe that marks the end of each instruction. At such a boundary, if an enabled flag is raised and the mask is clear, the block takes the interrupt. It saves the return context onto a descending stack and then reads the two-byte service address of the winning source from a vector table. Finally it hands back the new program counter, the updated stack pointer and a condition byte with the mask set.

The block uses two byte-wide memory ports, both valid/ready. On the write port, a beat moves on any edge where `mem_wr_valid` and `mem_wr_ready` are both high. While `mem_wr_ready` is low, the block holds address and data stable. The read port works the same way for requests. The addressed byte returns on `mem_rd_rvalid` some cycles after the request is accepted, and that return path has no back-pressure. A stall on either port simply lengthens the sequence.

Top module: `irq_entry_seq`

## Requirements
- R1: A sequence starts only on a clock edge where `insn_end` is high, `busy` is low, at least one source has both `irq_flag[i]` and `irq_en[i]` set, and bit 3 of `ccr_in` (the global mask) is 0.
- R2: If the mask bit is 1, if `insn_end` is low, or if no raised flag is enabled, no sequence starts. In that case `busy` stays low and no write beat is issued.
- R3: The stack receives exactly five write beats, in this order: PC low, PC high, X, A, condition byte. The addresses are SP, SP-1, SP-2, SP-3 and SP-4, where SP is `sp_in` captured at start. When the sequence ends, `new_sp` equals SP-5.
- R4: The stacked condition byte is the value captured at start, with its mask bit still clear. `new_ccr` equals that value with bit 3 forced to 1.
- R5: Among eligible sources, the lowest index wins. `src_sel` reports the winner.
- R6: The winner is captured when the sequence starts. Flag or enable changes during the sequence do not alter `src_sel` or the vector addresses read.
- R7: Source i has its high vector byte at `VEC_BASE - 2*i` and its low byte at the next address up. The high byte is read first. `new_pc` is `{high, low}`.
- R8: A request on either memory port keeps valid, address and (for writes) data unchanged until the cycle it is accepted. No read request is made before all five writes have been accepted.
- R9: `busy` rises on the edge after the start edge. It stays high until the low vector byte returns. On the following edge it falls and `done` pulses high for exactly one cycle, with `new_pc`, `new_sp` and `new_ccr` valid from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_flag | input | NSRC | Per-source pending flags |
| irq_en | input | NSRC | Per-source local enables |
| insn_end | input | 1 | Instruction boundary strobe |
| ccr_in | input | 8 | Current condition byte, mask at bit 3 |
| pc_in | input | AW | Return address to save |
| x_in | input | 8 | Index register to save |
| a_in | input | 8 | Accumulator to save |
| sp_in | input | AW | Stack pointer before entry |
| mem_wr_valid | output | 1 | Write beat offered |
| mem_wr_ready | input | 1 | Write beat accepted |
| mem_wr_addr | output | AW | Write address |
| mem_wr_data | output | 8 | Write byte |
| mem_rd_valid | output | 1 | Read request offered |
| mem_rd_ready | input | 1 | Read request accepted |
| mem_rd_addr | output | AW | Read address |
| mem_rd_rvalid | input | 1 | Read byte returning |
| mem_rd_rdata | input | 8 | Returned byte |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| src_sel | output | IDXW | Index of serviced source |
| new_pc | output | AW | Service routine address |
| new_sp | output | AW | Stack pointer after pushes |
| new_ccr | output | 8 | Condition byte with mask set |

## Verification
A wrong push counter or wrong stack arithmetic shows up on the write port at the first misplaced beat. That is within five accepted writes of the start. A wrong winner, or a winner captured too late, shows up as a wrong read address on the first vector request. A mask gate that leaks, or a boundary gate that leaks, raises `busy` one edge after the bad strobe. A stale or unset mask bit is visible on `new_ccr` in the same cycle as `done`.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PUSH  = 3'd1,
    ST_HREQ  = 3'd2,
    ST_HWAIT = 3'd3,
    ST_LREQ  = 3'd4,
    ST_LWAIT = 3'd5
  } seq_state_t;

  localparam int unsigned PUSH_BYTES = 5;
  localparam int unsigned MASK_BIT   = 3;
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned NSRC = 8,
  localparam int unsigned IDXW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0] req,
  output logic            any,
  output logic [IDXW-1:0] idx
);
  logic [NSRC-1:0] grant;

  for (genvar i = 0; i < NSRC; i++) begin : g_grant
    if (i == 0) begin : g_top
      assign grant[i] = req[i];
    end else begin : g_rest
      assign grant[i] = req[i] & ~(|req[i-1:0]);
    end
  end

  always_comb begin
    idx = '0;
    for (int k = 0; k < NSRC; k++) begin
      if (grant[k]) idx = idx | IDXW'(k);
    end
  end

  assign any = |req;

  always_comb begin
    a_onehot_r5: assert ($onehot0(grant));
  end
endmodule

// File: rtl/irq_vec_addr.sv
module irq_vec_addr #(
  parameter int unsigned NSRC = 8,
  parameter int unsigned AW = 16,
  parameter logic [AW-1:0] VEC_BASE = 16'hFFFE,
  localparam int unsigned IDXW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [IDXW-1:0] idx,
  output logic [AW-1:0]   hi_addr,
  output logic [AW-1:0]   lo_addr
);
  assign hi_addr = VEC_BASE - AW'({idx, 1'b0});
  assign lo_addr = hi_addr + AW'(1);
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int unsigned NSRC = 8,
  parameter int unsigned AW = 16,
  parameter logic [AW-1:0] VEC_BASE = 16'hFFFE,
  localparam int unsigned IDXW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_flag,
  input  logic [NSRC-1:0] irq_en,
  input  logic            insn_end,
  input  logic [7:0]      ccr_in,
  input  logic [AW-1:0]   pc_in,
  input  logic [7:0]      x_in,
  input  logic [7:0]      a_in,
  input  logic [AW-1:0]   sp_in,
  output logic            mem_wr_valid,
  input  logic            mem_wr_ready,
  output logic [AW-1:0]   mem_wr_addr,
  output logic [7:0]      mem_wr_data,
  output logic            mem_rd_valid,
  input  logic            mem_rd_ready,
  output logic [AW-1:0]   mem_rd_addr,
  input  logic            mem_rd_rvalid,
  input  logic [7:0]      mem_rd_rdata,
  output logic            busy,
  output logic            done,
  output logic [IDXW-1:0] src_sel,
  output logic [AW-1:0]   new_pc,
  output logic [AW-1:0]   new_sp,
  output logic [7:0]      new_ccr
);
  seq_state_t      state;
  logic [2:0]      push_cnt;
  logic [AW-1:0]   pc_q, sp_q;
  logic [7:0]      x_q, a_q, ccr_q, vhi_q;
  logic [NSRC-1:0] eligible;
  logic            any_req, start, wr_fire, rd_fire;
  logic [IDXW-1:0] win_idx;
  logic [AW-1:0]   vhi_addr, vlo_addr;

  assign eligible = irq_flag & irq_en;

  irq_prio_pick #(.NSRC(NSRC)) u_pick (
    .req(eligible), .any(any_req), .idx(win_idx)
  );

  irq_vec_addr #(.NSRC(NSRC), .AW(AW), .VEC_BASE(VEC_BASE)) u_vec (
    .idx(src_sel), .hi_addr(vhi_addr), .lo_addr(vlo_addr)
  );

  assign start   = (state == ST_IDLE) && insn_end && any_req && !ccr_in[MASK_BIT];
  assign wr_fire = mem_wr_valid && mem_wr_ready;
  assign rd_fire = mem_rd_valid && mem_rd_ready;

  assign busy         = (state != ST_IDLE);
  assign mem_wr_valid = (state == ST_PUSH);
  assign mem_wr_addr  = sp_q - AW'(push_cnt);
  assign mem_rd_valid = (state == ST_HREQ) || (state == ST_LREQ);
  assign mem_rd_addr  = (state == ST_LREQ) ? vlo_addr : vhi_addr;

  always_comb begin
    case (push_cnt)
      3'd0:    mem_wr_data = pc_q[7:0];
      3'd1:    mem_wr_data = pc_q[15:8];
      3'd2:    mem_wr_data = x_q;
      3'd3:    mem_wr_data = a_q;
      default: mem_wr_data = ccr_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      push_cnt <= '0;
      pc_q     <= '0;
      sp_q     <= '0;
      x_q      <= '0;
      a_q      <= '0;
      ccr_q    <= '0;
      vhi_q    <= '0;
      src_sel  <= '0;
      done     <= 1'b0;
      new_pc   <= '0;
      new_sp   <= '0;
      new_ccr  <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          state    <= ST_PUSH;
          push_cnt <= '0;
          pc_q     <= pc_in;
          sp_q     <= sp_in;
          x_q      <= x_in;
          a_q      <= a_in;
          ccr_q    <= ccr_in;
          src_sel  <= win_idx;
        end
        ST_PUSH: if (wr_fire) begin
          if (push_cnt == 3'(PUSH_BYTES - 1)) state <= ST_HREQ;
          else push_cnt <= push_cnt + 3'd1;
        end
        ST_HREQ:  if (rd_fire) state <= ST_HWAIT;
        ST_HWAIT: if (mem_rd_rvalid) begin
          vhi_q <= mem_rd_rdata;
          state <= ST_LREQ;
        end
        ST_LREQ:  if (rd_fire) state <= ST_LWAIT;
        ST_LWAIT: if (mem_rd_rvalid) begin
          state   <= ST_IDLE;
          done    <= 1'b1;
          new_pc  <= {vhi_q, mem_rd_rdata};
          new_sp  <= sp_q - AW'(PUSH_BYTES);
          new_ccr <= ccr_q | (8'd1 << MASK_BIT);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_start_gated_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(insn_end && (|(irq_flag & irq_en)) && !ccr_in[MASK_BIT]));
  p_masked_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ccr_in[MASK_BIT]) |=> !busy);
  p_mask_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> new_ccr[MASK_BIT]);
  p_win_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(src_sel));
  p_wr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && !mem_wr_ready) |=> (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));
  p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));
  p_port_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wr_valid && mem_rd_valid));
  p_done_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/irq_entry_seq_test.sv
module irq_entry_seq_test;
  localparam int unsigned NSRC = 8;
  localparam int unsigned AW = 16;
  localparam logic [15:0] VB = 16'hFFFE;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NSRC-1:0] irq_flag = '0, irq_en = '0;
  logic insn_end = 1'b0;
  logic [7:0] ccr_in = '0, x_in = '0, a_in = '0;
  logic [15:0] pc_in = '0, sp_in = '0;
  logic mem_wr_valid, mem_rd_valid, busy, done;
  logic mem_wr_ready = 1'b0, mem_rd_ready = 1'b0, mem_rd_rvalid = 1'b0;
  logic [15:0] mem_wr_addr, mem_rd_addr, new_pc, new_sp;
  logic [7:0] mem_wr_data, mem_rd_rdata = '0, new_ccr;
  logic [2:0] src_sel;

  int n_chk = 0, n_err = 0;
  logic [15:0] wa [0:7];
  logic [7:0]  wd [0:7];
  logic [15:0] ra [0:3];
  int wcnt = 0, rcnt = 0;
  logic [3:0] lfsr = 4'h9;
  logic stall_en = 1'b0;

  always #2 clk = ~clk;

  irq_entry_seq #(.NSRC(NSRC), .AW(AW), .VEC_BASE(VB)) uut (
    .clk(clk), .rst_n(rst_n), .irq_flag(irq_flag), .irq_en(irq_en),
    .insn_end(insn_end), .ccr_in(ccr_in), .pc_in(pc_in), .x_in(x_in),
    .a_in(a_in), .sp_in(sp_in), .mem_wr_valid(mem_wr_valid),
    .mem_wr_ready(mem_wr_ready), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .mem_rd_valid(mem_rd_valid),
    .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rd_rvalid(mem_rd_rvalid), .mem_rd_rdata(mem_rd_rdata),
    .busy(busy), .done(done), .src_sel(src_sel), .new_pc(new_pc),
    .new_sp(new_sp), .new_ccr(new_ccr)
  );

  function automatic logic [7:0] vbyte(input logic [15:0] ad);
    return ad[7:0] ^ 8'hA5;
  endfunction

  // memory model: ready stalls from an LFSR, read data one cycle after accept
  always @(posedge clk) begin
    lfsr <= {lfsr[2:0], lfsr[3] ^ lfsr[2]};
    mem_wr_ready <= stall_en ? lfsr[0] : 1'b1;
    mem_rd_ready <= stall_en ? lfsr[1] : 1'b1;
    mem_rd_rvalid <= 1'b0;
    if (mem_wr_valid && mem_wr_ready) begin
      if (wcnt < 8) begin wa[wcnt] <= mem_wr_addr; wd[wcnt] <= mem_wr_data; end
      wcnt <= wcnt + 1;
    end
    if (mem_rd_valid && mem_rd_ready) begin
      if (rcnt < 4) ra[rcnt] <= mem_rd_addr;
      rcnt <= rcnt + 1;
      mem_rd_rvalid <= 1'b1;
      mem_rd_rdata <= vbyte(mem_rd_addr);
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_logs();
    @(negedge clk);
    wcnt = 0; rcnt = 0;
  endtask

  // Strobe a boundary, then wait for done; checks all results
  task automatic take_irq(input logic [7:0] fl, input logic [7:0] en,
                          input logic [7:0] late_fl, input int exp_src);
    logic [15:0] hi, lo;
    int cyc;
    clear_logs();
    irq_flag = fl; irq_en = en; ccr_in = 8'h60;
    pc_in = 16'hBEEF ^ {8'h0, fl}; x_in = 8'h11 + fl; a_in = 8'h22 ^ en;
    sp_in = 16'h00F0 + {8'h0, fl};
    insn_end = 1'b1;
    @(negedge clk);
    insn_end = 1'b0;
    chk(busy === 1'b1, "R9 busy after start", {31'b0, busy}, 1);
    irq_flag = late_fl; irq_en = 8'hFF;
    cyc = 0;
    while (done !== 1'b1 && cyc < 300) begin @(negedge clk); cyc++; end
    chk(cyc < 300, "R9 done reached", cyc, 0);
    chk(busy === 1'b0, "R9 busy low at done", {31'b0, busy}, 0);
    chk(wcnt == 5, "R3 write count", wcnt, 5);
    for (int k = 0; k < 5; k++)
      chk(wa[k] === sp_in - 16'(k), "R3 push address", {16'b0, wa[k]}, {16'b0, sp_in - 16'(k)});
    chk(wd[0] === pc_in[7:0], "R3 PCL", {24'b0, wd[0]}, {24'b0, pc_in[7:0]});
    chk(wd[1] === pc_in[15:8], "R3 PCH", {24'b0, wd[1]}, {24'b0, pc_in[15:8]});
    chk(wd[2] === x_in, "R3 X", {24'b0, wd[2]}, {24'b0, x_in});
    chk(wd[3] === a_in, "R3 A", {24'b0, wd[3]}, {24'b0, a_in});
    chk(wd[4] === 8'h60, "R4 stacked ccr", {24'b0, wd[4]}, 32'h60);
    chk(new_ccr === 8'h68, "R4 new ccr mask", {24'b0, new_ccr}, 32'h68);
    chk(new_sp === sp_in - 16'd5, "R3 new sp", {16'b0, new_sp}, {16'b0, sp_in - 16'd5});
    chk(src_sel === 3'(exp_src), "R5 R6 winner", {29'b0, src_sel}, exp_src);
    hi = VB - 16'(2 * exp_src); lo = hi + 16'd1;
    chk(rcnt == 2 && ra[0] === hi && ra[1] === lo, "R7 vector addresses",
        {ra[0], ra[1]}, {hi, lo});
    chk(new_pc === {vbyte(hi), vbyte(lo)}, "R7 new pc", {16'b0, new_pc}, {16'b0, vbyte(hi), vbyte(lo)});
    @(negedge clk);
    chk(done === 1'b0, "R9 done single pulse", {31'b0, done}, 0);
    irq_flag = '0; irq_en = '0;
  endtask

  // A boundary that must not start anything
  task automatic no_start(input logic [7:0] fl, input logic [7:0] en,
                          input logic [7:0] ccr, input logic strobe, input string tag);
    clear_logs();
    irq_flag = fl; irq_en = en; ccr_in = ccr; insn_end = strobe;
    @(negedge clk);
    insn_end = 1'b0;
    repeat (4) @(negedge clk);
    chk(busy === 1'b0 && wcnt == 0, tag, {wcnt[30:0], busy}, 0);
    irq_flag = '0; irq_en = '0; ccr_in = '0;
  endtask

  task automatic reset_state();
    chk(busy === 1'b0 && done === 1'b0 && mem_wr_valid === 1'b0 && mem_rd_valid === 1'b0,
        "R9 reset idle", {28'b0, busy, done, mem_wr_valid, mem_rd_valid}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    reset_state();
    take_irq(8'h04, 8'h04, 8'h00, 2);          // R1 single source
    take_irq(8'hA6, 8'hFF, 8'h00, 1);          // R5 lowest index wins
    take_irq(8'h81, 8'h80, 8'h00, 7);          // R1 enable masks source 0
    take_irq(8'h20, 8'h20, 8'h01, 5);          // R6 late higher request ignored
    stall_en = 1'b1;
    take_irq(8'h09, 8'h0F, 8'h00, 0);          // R8 under back-pressure
    take_irq(8'h40, 8'h40, 8'h02, 6);          // R8 R6 stalls plus late request
    stall_en = 1'b0;
    no_start(8'h01, 8'h01, 8'h08, 1'b1, "R2 masked");
    no_start(8'h01, 8'h01, 8'h00, 1'b0, "R2 no boundary");
    no_start(8'hF0, 8'h0F, 8'h00, 1'b1, "R2 not enabled");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule